// File: doc/BRIEF.md
# Configuration Space Register File

This block holds the 256-byte configuration space of one device function. A host-side agent reaches it through a single-cycle register port. The port carries a byte offset, a length of one, two or four bytes, write data, and a read/write select. Writes are broken into single bytes. Each byte is then dropped or kept according to a write-protect map, and the header type byte chooses which map applies. Read data comes back little-endian one cycle after the request.

Base address registers get special handling on an aligned full-word write. The low address bits that fall inside a region's size always read back as that region's fixed type bits, so software can write all ones and read back the region size. The expansion ROM base keeps its enable bit as well. The command register and every base register are also driven out as plain outputs, so the address decoders next to the block can use them.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset every byte reads zero, with three exceptions. Offset 0x0e holds the header type parameter. The word of each base register i that has a non-zero size holds that register's type bits. The ROM base word at 0x30 holds zero.
- R2: `len_i` encodes the access length: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. A write sends byte i of `wdata_i` to offset `addr_i`+i. A read returns the byte at `addr_i` in bits 7:0 and the next bytes above it, and the bytes beyond the length are zero. `rvalid_o` and `rdata_o` appear on the cycle after a read request.
- R3: A four-byte read at an offset above 0xfc returns two bytes if the offset is at most 0xfe, and otherwise one byte. A two-byte read at 0xff returns one byte.
- R4: A write stores no byte beyond offset 0xff.
- R5: With header type 0x00 or 0x80, writes leave these bytes unchanged: 0x00-0x03, 0x06-0x0b, 0x0e, 0x10-0x27, 0x2c-0x2f, 0x30-0x33 and 0x3d.
- R6: With any other header type, writes leave these bytes unchanged: 0x00-0x03, 0x06-0x0b, 0x0e, 0x2c-0x2f, 0x38-0x3b and 0x3d. The bytes 0x10-0x27 and 0x30-0x33 can be written.
- R7: A four-byte write at a word-aligned offset 0x10+4i, for a base register with non-zero size S and type T, stores (data AND NOT(S-1)) OR T. This happens under either header type, whatever the protect map says.
- R8: A four-byte write at 0x30, when the ROM size S is non-zero, stores data AND (NOT(S-1) OR 1).
- R9: A base or ROM word write to a region of size zero, and any unaligned or shorter write to those offsets, goes through the ordinary byte path of R5 and R6.
- R10: A write to offset 0x05 keeps only bits 2:0 of its byte, so bits 15:11 of the command register stay zero.
- R11: `cmd_o` is bytes 0x05:0x04. Slice i of `bar_o` is the word at 0x10+4i. `rom_bar_o` is the word at 0x30. All of them change on the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 8 | Byte offset |
| len_i | input | 2 | Access length code |
| wdata_i | input | 32 | Write data, lowest offset in bits 7:0 |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| cmd_o | output | 16 | Command register |
| bar_o | output | 192 | Six base register words, register i in bits 32i+31:32i |
| rom_bar_o | output | 32 | ROM base register word |

## Verification
The bound assertions check several properties on every cycle. Read valid must follow exactly the read requests. Upper read bytes must be zero when a read shrinks near the end of the space. The header type byte and the identity bytes must never move. The reserved command bits must stay clear. Under the type-0 map, every sized base register and the ROM base must keep their hard-wired low bits whatever is written. Only the bench's scenarios can show which bytes a given write actually changes: the two protect maps side by side, the truncation at 0xff, the masking of base register values, and the byte-lane order of reads and writes.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned LANES       = DATA_W / 8;
  localparam int unsigned CFG_BYTES   = 1 << ADDR_W;
  localparam int unsigned NUM_BARS    = 6;
  localparam int unsigned NUM_REGIONS = NUM_BARS + 1;
  localparam int unsigned ROM_IDX     = NUM_BARS;

  localparam logic [ADDR_W-1:0] CMD_OFS     = 8'h04;
  localparam logic [ADDR_W-1:0] CMD_HI_OFS  = 8'h05;
  localparam logic [7:0]        CMD_HI_KEEP = 8'h07;
  localparam logic [ADDR_W-1:0] HDR_OFS     = 8'h0e;
  localparam logic [ADDR_W-1:0] BAR_BASE    = 8'h10;
  localparam logic [ADDR_W-1:0] BAR_END     = 8'(BAR_BASE + 4 * NUM_BARS);
  localparam logic [ADDR_W-1:0] ROM_OFS     = 8'h30;

  typedef enum logic [1:0] {
    LEN_BYTE  = 2'd0,
    LEN_HALF  = 2'd1,
    LEN_WORD  = 2'd2,
    LEN_WORD2 = 2'd3
  } acc_len_e;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] ofs;
    logic [7:0]        data;
  } lane_t;

  function automatic logic is_type0_hdr(logic [7:0] hdr);
    return (hdr == 8'h00) || (hdr == 8'h80);
  endfunction

  // write-protect map, selected by header type
  function automatic logic is_ro(logic [7:0] hdr, logic [ADDR_W-1:0] a);
    logic shared;
    shared = (a <= 8'h03) || (a >= 8'h06 && a <= 8'h0b) || (a == HDR_OFS) ||
             (a >= 8'h2c && a <= 8'h2f) || (a == 8'h3d);
    if (is_type0_hdr(hdr))
      return shared || (a >= BAR_BASE && a < BAR_END) || (a >= ROM_OFS && a <= 8'h33);
    else
      return shared || (a >= 8'h38 && a <= 8'h3b);
  endfunction

endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfg_space_pkg::*;
#(
  parameter logic [7:0]                        HDR_TYPE = 8'h00,
  parameter logic [NUM_REGIONS-1:0][DATA_W-1:0] BAR_SIZE = '0,
  parameter logic [NUM_BARS-1:0][DATA_W-1:0]    BAR_TYPE = '0
) (
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              len_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output lane_t [LANES-1:0]       lanes_o
);

  logic              word_acc;
  logic [2:0]        nbytes;
  logic              is_rom;
  logic              bar_hit;
  logic              bar_path;
  logic [DATA_W-1:0] sz;
  logic [DATA_W-1:0] typ;
  logic [DATA_W-1:0] bar_val;

  always_comb begin
    word_acc = len_i[1];
    if (word_acc)                nbytes = 3'd4;
    else if (len_i == LEN_HALF)  nbytes = 3'd2;
    else                         nbytes = 3'd1;

    is_rom  = (addr_i == ROM_OFS);
    bar_hit = word_acc && (addr_i[1:0] == 2'b00) &&
              ((addr_i >= BAR_BASE && addr_i < BAR_END) || is_rom);

    sz  = '0;
    typ = '0;
    if (is_rom) sz = BAR_SIZE[ROM_IDX];
    for (int k = 0; k < NUM_BARS; k++) begin
      if (addr_i[ADDR_W-1:2] == 6'(6'(BAR_BASE >> 2) + 6'(k))) begin
        sz  = BAR_SIZE[k];
        typ = BAR_TYPE[k];
      end
    end

    bar_path = wr_en_i && bar_hit && (sz != '0);
    if (is_rom) bar_val = wdata_i & (~(sz - 32'd1) | 32'd1);
    else        bar_val = (wdata_i & ~(sz - 32'd1)) | typ;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W:0] ofs_ext;
    assign ofs_ext = {1'b0, addr_i} + (ADDR_W + 1)'(i);

    always_comb begin
      lanes_o[i].ofs = ofs_ext[ADDR_W-1:0];
      if (bar_path) begin
        lanes_o[i].en   = 1'b1;
        lanes_o[i].data = bar_val[8*i +: 8];
      end else begin
        lanes_o[i].en   = wr_en_i && (3'(i) < nbytes) && !ofs_ext[ADDR_W] &&
                          !is_ro(HDR_TYPE, ofs_ext[ADDR_W-1:0]);
        lanes_o[i].data = wdata_i[8*i +: 8];
        if (ofs_ext[ADDR_W-1:0] == CMD_HI_OFS)
          lanes_o[i].data = wdata_i[8*i +: 8] & CMD_HI_KEEP;
      end
    end
  end

endmodule

// File: rtl/cfg_byte_array.sv
module cfg_byte_array
  import cfg_space_pkg::*;
#(
  parameter logic [7:0]                        HDR_TYPE = 8'h00,
  parameter logic [NUM_REGIONS-1:0][DATA_W-1:0] BAR_SIZE = '0,
  parameter logic [NUM_BARS-1:0][DATA_W-1:0]    BAR_TYPE = '0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  lane_t [LANES-1:0]            lanes_i,
  output logic [CFG_BYTES-1:0][7:0]    cfg_o
);

  function automatic logic [7:0] rst_byte(int j);
    int off;
    if (j == int'(HDR_OFS)) return HDR_TYPE;
    for (int k = 0; k < NUM_BARS; k++) begin
      off = j - int'(BAR_BASE) - 4 * k;
      if (BAR_SIZE[k] != '0 && off >= 0 && off < 4)
        return BAR_TYPE[k][8*off +: 8];
    end
    return 8'h00;
  endfunction

  for (genvar j = 0; j < CFG_BYTES; j++) begin : g_byte
    localparam logic [7:0] RST_VAL = rst_byte(j);
    logic       hit;
    logic [7:0] nxt;
    logic [7:0] byte_q;

    always_comb begin
      hit = 1'b0;
      nxt = byte_q;
      for (int l = 0; l < LANES; l++) begin
        if (lanes_i[l].en && lanes_i[l].ofs == ADDR_W'(j)) begin
          hit = 1'b1;
          nxt = lanes_i[l].data;
        end
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  byte_q <= RST_VAL;
      else if (hit) byte_q <= nxt;
    end

    assign cfg_o[j] = byte_q;
  end

endmodule

// File: rtl/cfg_rd_port.sv
module cfg_rd_port
  import cfg_space_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [1:0]                len_i,
  input  logic [CFG_BYTES-1:0][7:0] cfg_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o
);

  logic [2:0]        nbytes;
  logic [DATA_W-1:0] rd_word;

  // over-length reads near the top shrink rather than wrap
  always_comb begin
    if (len_i[1] && addr_i <= 8'hfc)                nbytes = 3'd4;
    else if (len_i != LEN_BYTE && addr_i <= 8'hfe)  nbytes = 3'd2;
    else                                            nbytes = 3'd1;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rd
    logic [ADDR_W-1:0] ofs;
    assign ofs = addr_i + ADDR_W'(i);
    assign rd_word[8*i +: 8] = (3'(i) < nbytes) ? cfg_i[ofs] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_word;
    end
  end

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
  import cfg_space_pkg::*;
#(
  parameter logic [7:0]                        HDR_TYPE = 8'h00,
  parameter logic [NUM_REGIONS-1:0][DATA_W-1:0] BAR_SIZE = {32'h0000_0800, 32'h0, 32'h0, 32'h0,
                                                            32'h0, 32'h0000_0020, 32'h0000_1000},
  parameter logic [NUM_BARS-1:0][DATA_W-1:0]    BAR_TYPE = {32'h0, 32'h0, 32'h0, 32'h0,
                                                            32'h1, 32'h0}
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [7:0]                   addr_i,
  input  logic [1:0]                   len_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output logic                         rvalid_o,
  output logic [15:0]                  cmd_o,
  output logic [6*32-1:0]              bar_o,
  output logic [31:0]                  rom_bar_o
);

  logic [CFG_BYTES-1:0][7:0] cfg_q;
  lane_t [LANES-1:0]         lanes;

  cfg_wr_decode #(
    .HDR_TYPE (HDR_TYPE),
    .BAR_SIZE (BAR_SIZE),
    .BAR_TYPE (BAR_TYPE)
  ) wr_dec_i (
    .wr_en_i (req_i && we_i),
    .addr_i  (addr_i),
    .len_i   (len_i),
    .wdata_i (wdata_i),
    .lanes_o (lanes)
  );

  cfg_byte_array #(
    .HDR_TYPE (HDR_TYPE),
    .BAR_SIZE (BAR_SIZE),
    .BAR_TYPE (BAR_TYPE)
  ) store_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lanes_i (lanes),
    .cfg_o   (cfg_q)
  );

  cfg_rd_port rd_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (req_i && !we_i),
    .addr_i   (addr_i),
    .len_i    (len_i),
    .cfg_i    (cfg_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  assign cmd_o = {cfg_q[int'(CMD_OFS) + 1], cfg_q[int'(CMD_OFS)]};

  for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar
    localparam int B = int'(BAR_BASE) + 4 * k;
    assign bar_o[32*k +: 32] = {cfg_q[B+3], cfg_q[B+2], cfg_q[B+1], cfg_q[B]};
  end

  assign rom_bar_o = {cfg_q[int'(ROM_OFS) + 3], cfg_q[int'(ROM_OFS) + 2],
                      cfg_q[int'(ROM_OFS) + 1], cfg_q[int'(ROM_OFS)]};

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk
  import cfg_space_pkg::*;
#(
  parameter logic [7:0]                        HDR_TYPE = 8'h00,
  parameter logic [NUM_REGIONS-1:0][DATA_W-1:0] BAR_SIZE = '0,
  parameter logic [NUM_BARS-1:0][DATA_W-1:0]    BAR_TYPE = '0
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [7:0]                addr_i,
  input logic [1:0]                len_i,
  input logic [31:0]               rdata_o,
  input logic                      rvalid_o,
  input logic [15:0]               cmd_o,
  input logic [6*32-1:0]           bar_o,
  input logic [31:0]               rom_bar_o,
  input logic [CFG_BYTES-1:0][7:0] cfg_q
);

  // R2
  rd_valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R3
  shrink_to_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 8'hff) |=> (rdata_o[31:8] == 24'h0));

  // R3
  shrink_to_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && len_i[1] && addr_i > 8'hfc && addr_i < 8'hff)
      |=> (rdata_o[31:16] == 16'h0));

  // R10
  cmd_reserved_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[15:11] == 5'h0);

  // R5
  hdr_byte_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[int'(HDR_OFS)] == HDR_TYPE);

  // R6
  id_bytes_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i |=> $stable({cfg_q[3], cfg_q[2], cfg_q[1], cfg_q[0]}));

  if (is_type0_hdr(HDR_TYPE)) begin : g_type0
    for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar
      if (BAR_SIZE[k] != '0) begin : g_sized
        // R7
        bar_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (bar_o[32*k +: 32] & (BAR_SIZE[k] - 32'd1)) ==
          (BAR_TYPE[k] & (BAR_SIZE[k] - 32'd1)));
      end
    end
    if (BAR_SIZE[ROM_IDX] != '0) begin : g_rom
      // R8
      rom_low_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rom_bar_o & (BAR_SIZE[ROM_IDX] - 32'd1) & ~32'd1) == 32'h0);
    end
  end

endmodule

bind cfg_space_regfile cfg_space_chk #(
  .HDR_TYPE (HDR_TYPE),
  .BAR_SIZE (BAR_SIZE),
  .BAR_TYPE (BAR_TYPE)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .len_i     (len_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .cmd_o     (cmd_o),
  .bar_o     (bar_o),
  .rom_bar_o (rom_bar_o),
  .cfg_q     (cfg_q)
);

// File: tb/cfg_space_regfile_tb.sv
module cfg_space_regfile_tb_top;

  localparam logic [6:0][31:0] A_SIZE = {32'h800, 32'h0, 32'h0, 32'h0, 32'h0, 32'h20, 32'h1000};
  localparam logic [5:0][31:0] A_TYPE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h1, 32'h0};
  localparam logic [6:0][31:0] B_SIZE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h10};
  localparam logic [5:0][31:0] B_TYPE = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1};
  localparam logic [7:0]       A_HDR  = 8'h00;
  localparam logic [7:0]       B_HDR  = 8'h01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  len = '0;
  logic [31:0] wdata = '0;

  logic [31:0]  rdata_a, rdata_b, rom_a, rom_b;
  logic         rvalid_a, rvalid_b;
  logic [15:0]  cmd_a, cmd_b;
  logic [191:0] bar_a, bar_b;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  logic [7:0]  mdl [2][256];
  logic [31:0] exp_a[$], exp_b[$];
  string       tag_a[$], tag_b[$];

  always #10 clk = ~clk;

  cfg_space_regfile #(.HDR_TYPE(A_HDR), .BAR_SIZE(A_SIZE), .BAR_TYPE(A_TYPE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .len_i(len),
    .wdata_i(wdata), .rdata_o(rdata_a), .rvalid_o(rvalid_a), .cmd_o(cmd_a),
    .bar_o(bar_a), .rom_bar_o(rom_a));

  cfg_space_regfile #(.HDR_TYPE(B_HDR), .BAR_SIZE(B_SIZE), .BAR_TYPE(B_TYPE)) dut_br_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .len_i(len),
    .wdata_i(wdata), .rdata_o(rdata_b), .rvalid_o(rvalid_b), .cmd_o(cmd_b),
    .bar_o(bar_b), .rom_bar_o(rom_b));

  function automatic logic [31:0] bsize(int m, int k);
    return (m == 0) ? A_SIZE[k] : B_SIZE[k];
  endfunction

  function automatic logic [31:0] btype(int m, int k);
    return (m == 0) ? A_TYPE[k] : B_TYPE[k];
  endfunction

  // protect lists of R5 / R6
  function automatic bit m_ro(int m, int a);
    bit c;
    c = (a <= 3) || (a >= 6 && a <= 11) || a == 14 || (a >= 44 && a <= 47) || a == 61;
    if (m == 0) return c || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
    return c || (a >= 56 && a <= 59);
  endfunction

  task automatic model_init(int m);
    for (int j = 0; j < 256; j++) mdl[m][j] = 8'h00;
    mdl[m][14] = (m == 0) ? A_HDR : B_HDR;
    for (int k = 0; k < 6; k++)
      if (bsize(m, k) != 0)
        for (int i = 0; i < 4; i++) mdl[m][16 + 4*k + i] = btype(m, k)[8*i +: 8];
  endtask

  task automatic model_write(int m, int a, int n, logic [31:0] v);
    bit bar;
    int k;
    logic [31:0] sz, w;
    logic [7:0] b;
    bar = (n == 4) && (a % 4 == 0) && ((a >= 16 && a < 40) || a == 48);
    k = (a == 48) ? 6 : (a - 16) / 4;
    if (bar && bsize(m, k) != 0) begin
      sz = bsize(m, k);
      if (k == 6) w = v & (~(sz - 1) | 32'd1);
      else        w = (v & ~(sz - 1)) | btype(m, k);
      for (int i = 0; i < 4; i++) mdl[m][a + i] = w[8*i +: 8];
    end else begin
      for (int i = 0; i < n; i++) begin
        if (a + i > 255) break;
        if (!m_ro(m, a + i)) begin
          b = v[8*i +: 8];
          if (a + i == 5) b = b & 8'h07;
          mdl[m][a + i] = b;
        end
      end
    end
  endtask

  function automatic logic [31:0] model_read(int m, int a, int n);
    int nb;
    logic [31:0] r;
    if (n == 4 && a <= 252)      nb = 4;
    else if (n >= 2 && a <= 254) nb = 2;
    else                         nb = 1;
    r = '0;
    for (int i = 0; i < nb; i++) r[8*i +: 8] = mdl[m][a + i];
    return r;
  endfunction

  function automatic logic [31:0] mword(int m, int a);
    return {mdl[m][a+3], mdl[m][a+2], mdl[m][a+1], mdl[m][a]};
  endfunction

  function automatic logic [1:0] len_code(int n);
    return (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_wr(int a, int n, logic [31:0] v);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'(a); len = len_code(n); wdata = v;
    model_write(0, a, n, v);
    model_write(1, a, n, v);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_rd(int a, int n, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'(a); len = len_code(n);
    exp_a.push_back(model_read(0, a, n)); tag_a.push_back({tag, " type0"});
    exp_b.push_back(model_read(1, a, n)); tag_b.push_back({tag, " bridge"});
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_ports(string tag);
    chk({tag, " cmd type0"}, {16'h0, cmd_a}, {16'h0, mdl[0][5], mdl[0][4]});
    chk({tag, " cmd bridge"}, {16'h0, cmd_b}, {16'h0, mdl[1][5], mdl[1][4]});
    for (int k = 0; k < 6; k++) begin
      chk({tag, " bar type0"}, bar_a[32*k +: 32], mword(0, 16 + 4*k));
      chk({tag, " bar bridge"}, bar_b[32*k +: 32], mword(1, 16 + 4*k));
    end
    chk({tag, " rom type0"}, rom_a, mword(0, 48));
    chk({tag, " rom bridge"}, rom_b, mword(1, 48));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid_a) begin
      if (exp_a.size() == 0) chk("R2 unexpected valid type0", 32'h1, 32'h0);
      else chk(tag_a.pop_front(), rdata_a, exp_a.pop_front());
    end
    if (rst_n && rvalid_b) begin
      if (exp_b.size() == 0) chk("R2 unexpected valid bridge", 32'h1, 32'h0);
      else chk(tag_b.pop_front(), rdata_b, exp_b.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_init(0);
    model_init(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset image
    chk_ports("R1");
    chk("R2 no valid at idle", {31'h0, rvalid_a}, 32'h0);
    do_rd(8'h00, 4, "R1 id word");
    do_rd(8'h0c, 4, "R1 header word");
    do_rd(8'h10, 4, "R1 bar0");
    do_rd(8'h14, 4, "R1 bar1");

    // R5 R6 identity bytes protected
    do_wr(8'h00, 4, 32'hdeadbeef);
    do_rd(8'h00, 4, "R5 id protected");
    do_wr(8'h0e, 1, 32'h0000005a);
    do_rd(8'h0e, 1, "R6 header protected");

    // R10 command high byte masking, status protected
    do_wr(8'h04, 4, 32'hffffffff);
    chk_ports("R10");
    do_rd(8'h04, 4, "R10 cmd/status word");

    // R7 base register masking
    do_wr(8'h10, 4, 32'h12345678);
    do_wr(8'h14, 4, 32'hffffffff);
    chk_ports("R7");
    do_rd(8'h10, 4, "R7 bar0 read");
    do_rd(8'h14, 4, "R7 bar1 read");

    // R9 unsized region and unaligned / short writes
    do_wr(8'h18, 4, 32'hcafef00d);
    do_wr(8'h11, 4, 32'h55aa55aa);
    do_wr(8'h14, 2, 32'h00009876);
    chk_ports("R9");
    do_rd(8'h18, 4, "R9 bar2 read");

    // R8 ROM enable bit kept
    do_wr(8'h30, 4, 32'habcdef01);
    chk_ports("R8");
    do_rd(8'h30, 4, "R8 rom read");
    do_wr(8'h30, 4, 32'hfffffffe);
    chk_ports("R8 enable cleared");

    // R5 R6 differing bytes
    do_wr(8'h38, 4, 32'h11223344);
    do_rd(8'h38, 4, "R6 0x38 word");
    do_wr(8'h3c, 2, 32'h00005566);
    do_rd(8'h3c, 4, "R5 0x3d protected");
    do_wr(8'h2c, 2, 32'h00001234);
    do_rd(8'h2c, 4, "R5 subsystem protected");
    do_wr(8'h28, 4, 32'h0badf00d);
    do_rd(8'h28, 4, "R5 0x28 writable");

    // R2 byte lanes
    do_wr(8'h40, 1, 32'h000000a1);
    do_wr(8'h41, 1, 32'h000000b2);
    do_wr(8'h42, 2, 32'h0000d4c3);
    do_rd(8'h40, 4, "R2 lane order");
    do_rd(8'h41, 2, "R2 half unaligned");
    do_rd(8'h43, 1, "R2 byte read");
    do_wr(8'h45, 4, 32'h89abcdef);
    do_rd(8'h44, 4, "R2 unaligned word");

    // R4 truncation at the top
    do_wr(8'hfe, 4, 32'ha1b2c3d4);
    do_wr(8'hff, 2, 32'h00007788);
    do_rd(8'hfc, 4, "R4 top word");

    // R3 read shrinking
    do_rd(8'hfd, 4, "R3 word to half");
    do_rd(8'hfe, 4, "R3 word to half at fe");
    do_rd(8'hff, 4, "R3 word to byte");
    do_rd(8'hff, 2, "R3 half to byte");
    do_rd(8'hfe, 1, "R3 byte at fe");

    // R11 final output image
    chk_ports("R11");

    repeat (3) @(negedge clk);
    chk("R2 queue drained type0", exp_a.size(), 32'h0);
    chk("R2 queue drained bridge", exp_b.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule